// File: doc/BRIEF.md
# Ethernet Receive Frame Processor

This block sits behind a byte-wide media-independent receive interface (data byte, data-valid, error) and turns the incoming stream into frames for an external FIFO write port. It looks for the start-of-frame delimiter and discards the preamble in front of it. It then passes the frame bytes on to the FIFO, either all of them or, when stripping is selected, without the trailing check sequence and without any pad bytes that the length field marks as filler.

While bytes pass through, the block checks the destination address against a programmed station address and runs the frame check sequence through a CRC-32. It also tracks the frame length, line errors, FIFO back-pressure losses and the idle gap in front of the frame. One cycle after data-valid drops, it presents a status word with a one-cycle qualifying strobe. A MAC control frame with a good CRC also raises a flag for a separate flow-control block. A single byte clock drives everything.

Top module: `rxf_receiver`

## Requirements
- R1: After reset, `fifo_wr_en`, `stat_en` and `fc_ctl_frame` are low. A delimiter seen while `cfg_enable` is 0 starts no frame, so that frame produces no FIFO write and no status.
- R2: While in the hunting state, every byte with `rx_dv` high up to and including the first 0xD5 is discarded. The byte after that 0xD5 is the first frame byte. This holds for any preamble length, including none.
- R3: With stripping off (latched from `cfg_strip` at the delimiter), every frame byte is written to the FIFO in order. Each write appears in the cycle after the edge that sampled its byte.
- R4: With stripping on, the last 4 frame bytes (the FCS) are never written. Each other byte is written in the cycle after the edge that sampled the byte four positions later.
- R5: With stripping on, frame bytes 12 and 13 form a big-endian length/type value L. If L < 46, only frame bytes 0 to 13+L are written. If L >= 46, only the FCS is removed.
- R6: When `rx_dv` is sampled low after a frame, `stat_en` is high for exactly the next cycle. `stat_vec[22:7]` then holds the number of frame bytes, counting from the first byte after the delimiter.
- R7: `stat_vec[1]` is set when the reflected CRC-32 register (polynomial 0x04C11DB7, preset all ones), run over all frame bytes, does not end at the good-frame residue 0xDEBB20E3.
- R8: `stat_vec[6]` is set when frame bytes 0 to 5 equal `cfg_station_addr`, where byte 0 is compared with bits 47:40.
- R9: `stat_vec[3]` is set for a frame of fewer than 64 bytes. `stat_vec[4]` is set for a frame of more than 1518 bytes.
- R10: `stat_vec[2]` is set when `rx_er` was high together with `rx_dv` on any frame byte.
- R11: `stat_vec[5]` is set when fewer than 12 cycles with `rx_dv` low separate the last `rx_dv`-high cycle before this frame from its first `rx_dv`-high cycle.
- R12: In a cycle where a write is due and `fifo_full` is high, `fifo_wr_en` stays low, that byte is lost, and `stat_vec[0]` is set for the frame.
- R13: `fc_ctl_frame` is high together with `stat_en` exactly when the frame has at least 14 bytes, bytes 12 and 13 equal 0x8808, and the CRC is good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Lets new frames start |
| cfg_strip | input | 1 | Removes FCS and pad before the FIFO |
| cfg_station_addr | input | 48 | Station address; bits 47:40 are compared with the first byte |
| rx_d | input | 8 | Received byte |
| rx_dv | input | 1 | Received byte is valid |
| rx_er | input | 1 | Line error on the current byte |
| fifo_wr_data | output | 8 | Byte to the FIFO |
| fifo_wr_en | output | 1 | FIFO write strobe |
| fifo_full | input | 1 | FIFO cannot take a byte |
| stat_en | output | 1 | One-cycle status qualifier |
| stat_vec | output | 23 | {length[15:0], addr match, gap short, long, short, line error, CRC error, overflow} |
| fc_ctl_frame | output | 1 | Good control frame seen, with stat_en |

## Verification
The stimulus includes frames with a long preamble, a short preamble and no preamble at all, which shows that delimiter detection does not rely on a fixed preamble count. In pass-through mode, the bench sends frames with a good FCS, a corrupted FCS, a matching destination and a foreign destination, so that a wrong CRC or address verdict cannot hide behind correct data. In strip mode it uses one length field below the pad threshold, one exactly at it and one type value above it, which separates FCS removal from pad removal at the boundary. Further cases cover short, long, line-error, back-pressured, tight-gap, control and disabled frames, and each of these moves one status bit or output without changing the others.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

   localparam int          LEN_W        = 16;
   localparam logic [7:0]  SFD_BYTE     = 8'hD5;
   localparam logic [31:0] CRC_POLY_REV = 32'hEDB88320;
   localparam logic [31:0] CRC_RESIDUE  = 32'hDEBB20E3;

   typedef enum logic {RXF_HUNT, RXF_BODY} rxf_state_t;

   typedef struct packed {
      logic [LEN_W-1:0] len;
      logic             addr_hit;
      logic             gap_short;
      logic             too_long;
      logic             too_short;
      logic             line_err;
      logic             fcs_bad;
      logic             fifo_lost;
   } rxf_status_t;

   localparam int RXF_STAT_W = $bits(rxf_status_t);

   function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
      logic [31:0] r;
      r = c ^ {24'd0, b};
      for (int i = 0; i < 8; i++) begin
         r = r[0] ? ((r >> 1) ^ CRC_POLY_REV) : (r >> 1);
      end
      return r;
   endfunction

endpackage

// File: rtl/rxf_crc_acc.sv
module rxf_crc_acc
   import rxf_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        init,
   input  logic        step,
   input  logic [7:0]  din,
   output logic [31:0] crc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc <= '1;
      end else if (init) begin
         crc <= '1;
      end else if (step) begin
         crc <= crc_step(crc, din);
      end
   end
endmodule

// File: rtl/rxf_hold.sv
module rxf_hold #(
   parameter int DEPTH = 4,
   parameter int W     = 8
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   logic [W-1:0] stg [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg[g] <= '0;
         end else if (shift) begin
            if (g == 0) stg[g] <= din;
            else        stg[g] <= stg[(g == 0) ? 0 : g-1];
         end
      end
   end

   assign dout = stg[DEPTH-1];
endmodule

// File: rtl/rxf_gap_mon.sv
module rxf_gap_mon #(
   parameter int IPG_MIN = 12
)(
   input  logic clk,
   input  logic rst_n,
   input  logic dv,
   output logic rise,
   output logic short_gap
);
   localparam int               CNT_W = $clog2(IPG_MIN + 1);
   localparam logic [CNT_W-1:0] LIM   = CNT_W'(IPG_MIN);

   logic [CNT_W-1:0] idle_cnt;
   logic             dv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_cnt <= LIM;
         dv_q     <= 1'b0;
      end else begin
         dv_q <= dv;
         if (dv)                   idle_cnt <= '0;
         else if (idle_cnt != LIM) idle_cnt <= idle_cnt + 1'b1;
      end
   end

   assign rise      = dv & ~dv_q;
   assign short_gap = rise & (idle_cnt < LIM);
endmodule

// File: rtl/rxf_receiver.sv
module rxf_receiver
   import rxf_pkg::*;
#(
   parameter int MIN_FRAME   = 64,
   parameter int MAX_FRAME   = 1518,
   parameter int IPG_MIN     = 12,
   parameter int MIN_PAYLOAD = 46,
   parameter bit HAS_STRIP   = 1'b1
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_enable,
   input  logic                  cfg_strip,
   input  logic [47:0]           cfg_station_addr,
   input  logic [7:0]            rx_d,
   input  logic                  rx_dv,
   input  logic                  rx_er,
   output logic [7:0]            fifo_wr_data,
   output logic                  fifo_wr_en,
   input  logic                  fifo_full,
   output logic                  stat_en,
   output logic [RXF_STAT_W-1:0] stat_vec,
   output logic                  fc_ctl_frame
);
   localparam int               FCS_BYTES  = 4;
   localparam int               ADDR_BYTES = 6;
   localparam int               HDR_BYTES  = 14;
   localparam int               LT_HI_POS  = 12;
   localparam int               LT_LO_POS  = 13;
   localparam logic [15:0]      CTL_TYPE   = 16'h8808;
   localparam logic [LEN_W-1:0] MIN_L      = LEN_W'(MIN_FRAME);
   localparam logic [LEN_W-1:0] MAX_L      = LEN_W'(MAX_FRAME);
   localparam logic [LEN_W-1:0] FCS_L      = LEN_W'(FCS_BYTES);

   if (MAX_FRAME <= MIN_FRAME || MAX_FRAME >= (1 << LEN_W) || IPG_MIN < 1 ||
       MIN_PAYLOAD < 1 || MIN_PAYLOAD > 1500) begin : g_bad_cfg
      $error("rxf_receiver: inconsistent frame size or gap parameters");
   end

   rxf_state_t       state;
   logic [LEN_W-1:0] pos, pos_inc, back;
   logic             da_ok, err_f, lost_f, ipg_pend, ipg_f;
   logic [15:0]      lt;
   logic [31:0]      crc;
   logic             rise, short_gap;
   logic             start_frame, take, close, lost_now;
   logic             wr_pend, nxt_pend, strip_on, pad_cut, ctl_hit;
   logic [7:0]       wr_byte, nxt_byte, held;
   logic [7:0]       sta [8];
   rxf_status_t      stat_nxt;

   for (genvar g = 0; g < 8; g++) begin : g_sta
      if (g < ADDR_BYTES) begin : g_use
         assign sta[g] = cfg_station_addr[47-8*g -: 8];
      end else begin : g_zero
         assign sta[g] = 8'h00;
      end
   end

   assign start_frame = (state == RXF_HUNT) & rx_dv & (rx_d == SFD_BYTE) & cfg_enable;
   assign take        = (state == RXF_BODY) & rx_dv;
   assign close       = (state == RXF_BODY) & ~rx_dv;
   assign pos_inc     = (pos == '1) ? pos : pos + 1'b1;
   assign back        = pos - FCS_L;
   assign lost_now    = wr_pend & fifo_full;

   rxf_crc_acc crc_i (
      .clk  (clk),
      .rst_n(rst_n),
      .init (start_frame),
      .step (take),
      .din  (rx_d),
      .crc  (crc)
   );

   rxf_gap_mon #(.IPG_MIN(IPG_MIN)) gap_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .dv       (rx_dv),
      .rise     (rise),
      .short_gap(short_gap)
   );

   if (HAS_STRIP) begin : g_strip
      logic strip_f;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           strip_f <= 1'b0;
         else if (start_frame) strip_f <= cfg_strip;
      end
      rxf_hold #(.DEPTH(FCS_BYTES), .W(8)) hold_i (
         .clk  (clk),
         .rst_n(rst_n),
         .shift(take),
         .din  (rx_d),
         .dout (held)
      );
      assign strip_on = strip_f;
   end else begin : g_pass
      assign held     = rx_d;
      assign strip_on = 1'b0;
   end

   assign pad_cut = (lt < 16'(MIN_PAYLOAD)) &&
                    ({1'b0, back} >= (17'(HDR_BYTES) + {1'b0, lt}));

   always_comb begin
      if (strip_on) begin
         nxt_pend = take && (pos >= FCS_L) && !pad_cut;
         nxt_byte = held;
      end else begin
         nxt_pend = take;
         nxt_byte = rx_d;
      end
   end

   always_comb begin
      stat_nxt           = '0;
      stat_nxt.len       = pos;
      stat_nxt.addr_hit  = da_ok && (pos >= LEN_W'(ADDR_BYTES));
      stat_nxt.gap_short = ipg_f;
      stat_nxt.too_long  = pos > MAX_L;
      stat_nxt.too_short = pos < MIN_L;
      stat_nxt.line_err  = err_f;
      stat_nxt.fcs_bad   = crc != CRC_RESIDUE;
      stat_nxt.fifo_lost = lost_f | lost_now;
   end

   assign ctl_hit = (lt == CTL_TYPE) && (crc == CRC_RESIDUE) && (pos >= LEN_W'(HDR_BYTES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= RXF_HUNT;
         pos          <= '0;
         da_ok        <= 1'b0;
         lt           <= '1;
         err_f        <= 1'b0;
         lost_f       <= 1'b0;
         ipg_pend     <= 1'b0;
         ipg_f        <= 1'b0;
         wr_pend      <= 1'b0;
         wr_byte      <= '0;
         stat_en      <= 1'b0;
         stat_vec     <= '0;
         fc_ctl_frame <= 1'b0;
      end else begin
         wr_pend      <= nxt_pend;
         if (nxt_pend) wr_byte <= nxt_byte;
         stat_en      <= close;
         fc_ctl_frame <= close & ctl_hit;
         if (close) stat_vec <= stat_nxt;
         if (rise)  ipg_pend <= short_gap;
         if (start_frame) begin
            state  <= RXF_BODY;
            pos    <= '0;
            da_ok  <= 1'b1;
            lt     <= '1;
            err_f  <= 1'b0;
            lost_f <= 1'b0;
            ipg_f  <= rise ? short_gap : ipg_pend;
         end else if (take) begin
            pos <= pos_inc;
            if (pos < LEN_W'(ADDR_BYTES))
               da_ok <= da_ok & (rx_d == sta[pos[2:0]]);
            if (pos == LEN_W'(LT_HI_POS)) lt[15:8] <= rx_d;
            if (pos == LEN_W'(LT_LO_POS)) lt[7:0]  <= rx_d;
            if (rx_er)    err_f  <= 1'b1;
            if (lost_now) lost_f <= 1'b1;
         end else if (close) begin
            state <= RXF_HUNT;
         end
      end
   end

   assign fifo_wr_en   = wr_pend & ~fifo_full;
   assign fifo_wr_data = wr_byte;

endmodule

// File: rtl/rxf_receiver_chk.sv
module rxf_receiver_chk
   import rxf_pkg::*;
(
   input logic                  clk,
   input logic                  rst_n,
   input logic                  rx_dv,
   input logic                  fifo_wr_en,
   input logic                  stat_en,
   input logic [RXF_STAT_W-1:0] stat_vec,
   input logic                  fc_ctl_frame
);
   // R6
   stat_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_en |=> !stat_en);

   // R6
   stat_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_en |-> !$past(rx_dv));

   // R3
   write_follows_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr_en |-> $past(rx_dv));

   // R13
   ctl_good_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fc_ctl_frame |-> (stat_en && !stat_vec[1]));

   // R9
   size_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_en |-> !(stat_vec[3] && stat_vec[4]));
endmodule

bind rxf_receiver rxf_receiver_chk chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .rx_dv       (rx_dv),
   .fifo_wr_en  (fifo_wr_en),
   .stat_en     (stat_en),
   .stat_vec    (stat_vec),
   .fc_ctl_frame(fc_ctl_frame)
);

// File: tb/rxf_receiver_tb_top.sv
`timescale 1ns/100ps
module rxf_receiver_tb_top;
   import rxf_pkg::*;

   typedef logic [7:0] bq_t[$];

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_enable = 1'b0;
   logic        cfg_strip = 1'b0;
   logic [47:0] cfg_station_addr = 48'h02_11_22_33_44_55;
   logic [7:0]  rx_d = 8'h00;
   logic        rx_dv = 1'b0;
   logic        rx_er = 1'b0;
   logic        fifo_full = 1'b0;
   logic [7:0]  fifo_wr_data;
   logic        fifo_wr_en;
   logic        stat_en;
   logic [RXF_STAT_W-1:0] stat_vec;
   logic        fc_ctl_frame;

   always #2.5 clk = ~clk;

   rxf_receiver dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_strip(cfg_strip),
      .cfg_station_addr(cfg_station_addr), .rx_d(rx_d), .rx_dv(rx_dv), .rx_er(rx_er),
      .fifo_wr_data(fifo_wr_data), .fifo_wr_en(fifo_wr_en), .fifo_full(fifo_full),
      .stat_en(stat_en), .stat_vec(stat_vec), .fc_ctl_frame(fc_ctl_frame)
   );

   int n_checks = 0, n_fail = 0;
   int idle_run = 1000;
   int writes_seen = 0, stats_seen = 0;
   string byte_tag = "R3";
   logic [7:0]            exp_bytes[$];
   logic [RXF_STAT_W-1:0] exp_stat[$];
   bit                    exp_fc[$];
   string                 exp_tag[$];

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // reference comparison on every clock, sampled just after the edge
   always @(posedge clk) begin
      #1;
      if (rst_n) begin
         if (fifo_wr_en) begin
            writes_seen++;
            if (exp_bytes.size() == 0) chk(1'b0, byte_tag, "unexpected FIFO write", fifo_wr_data, 0);
            else begin
               logic [7:0] e;
               e = exp_bytes.pop_front();
               chk(fifo_wr_data == e, byte_tag, "FIFO byte", fifo_wr_data, e);
            end
         end
         if (stat_en) begin
            stats_seen++;
            if (exp_stat.size() == 0) chk(1'b0, "R6", "unexpected status", stat_vec, 0);
            else begin
               logic [RXF_STAT_W-1:0] s;
               bit f;
               string t;
               s = exp_stat.pop_front();
               f = exp_fc.pop_front();
               t = exp_tag.pop_front();
               chk(stat_vec == s, t, "status vector", stat_vec, s);
               chk(fc_ctl_frame == f, "R13", "control flag", fc_ctl_frame, f);
            end
         end else if (fc_ctl_frame) begin
            chk(1'b0, "R13", "control flag without status", 1, 0);
         end
      end
   end

   function automatic logic [31:0] ref_fcs(bq_t q, int n);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int i = 0; i < n; i++) begin
         for (int b = 0; b < 8; b++) begin
            bit fb;
            fb = c[0] ^ q[i][b];
            c = c >> 1;
            if (fb) c = c ^ 32'hEDB88320;
         end
      end
      return ~c;
   endfunction

   function automatic bq_t mk(logic [47:0] da, logic [15:0] lt, int total, bit bad);
      bq_t q;
      logic [31:0] c;
      for (int i = 0; i < 6; i++) q.push_back(da[47-8*i -: 8]);
      for (int i = 0; i < 6; i++) q.push_back(8'hA0 + 8'(i));
      q.push_back(lt[15:8]);
      q.push_back(lt[7:0]);
      for (int i = 14; i < total - 4; i++) q.push_back(8'((i * 7 + 3) & 8'hFF));
      c = ref_fcs(q, q.size());
      for (int i = 0; i < 4; i++) q.push_back(c[8*i +: 8]);
      if (bad) q[q.size()-1] = q[q.size()-1] ^ 8'h01;
      return q;
   endfunction

   task automatic cyc(bit dv, logic [7:0] d, bit er);
      @(negedge clk);
      rx_dv = dv; rx_d = d; rx_er = er;
      if (dv) idle_run = 0;
      else    idle_run++;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 1'b0);
   endtask

   task automatic send(bq_t fr, int pre, int er_at, bit on, string btag, string stag);
      int n;
      int keep_n;
      logic [15:0] lt;
      bit bad;
      rxf_status_t s;
      n  = fr.size();
      lt = (n >= 14) ? {fr[12], fr[13]} : 16'hFFFF;
      if (n < 4) bad = 1'b1;
      else bad = ref_fcs(fr, n - 4) != {fr[n-1], fr[n-2], fr[n-3], fr[n-4]};
      if (on) begin
         keep_n = n;
         if (cfg_strip) begin
            keep_n = n - 4;
            if (lt < 46 && 14 + int'(lt) < keep_n) keep_n = 14 + int'(lt);
         end
         if (!fifo_full) for (int i = 0; i < keep_n; i++) exp_bytes.push_back(fr[i]);
         s           = '0;
         s.len       = 16'(n);
         s.addr_hit  = (n >= 6) && ({fr[0], fr[1], fr[2], fr[3], fr[4], fr[5]} == cfg_station_addr);
         s.gap_short = idle_run < 12;
         s.too_long  = n > 1518;
         s.too_short = n < 64;
         s.line_err  = er_at >= 0 && er_at < n;
         s.fcs_bad   = bad;
         s.fifo_lost = fifo_full && keep_n > 0;
         exp_stat.push_back(s);
         exp_fc.push_back(n >= 14 && lt == 16'h8808 && !bad);
         exp_tag.push_back(stag);
      end
      byte_tag = btag;
      for (int i = 0; i < pre; i++) cyc(1'b1, 8'h55, 1'b0);
      cyc(1'b1, 8'hD5, 1'b0);
      for (int i = 0; i < n; i++) cyc(1'b1, fr[i], i == er_at);
   endtask

   localparam logic [47:0] OTHER_DA = 48'h02_99_88_77_66_55;
   localparam logic [47:0] CTL_DA   = 48'h01_80_C2_00_00_01;

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin : main
      int w0, s0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      // R1 reset state
      chk(fifo_wr_en == 1'b0, "R1", "write after reset", fifo_wr_en, 0);
      chk(stat_en == 1'b0, "R1", "status after reset", stat_en, 0);
      chk(fc_ctl_frame == 1'b0, "R1", "control after reset", fc_ctl_frame, 0);

      // R1 disabled receiver ignores a frame
      idle(20);
      w0 = writes_seen; s0 = stats_seen;
      send(mk(cfg_station_addr, 16'h0800, 64, 1'b0), 7, -1, 1'b0, "R1", "R1");
      idle(20);
      chk(writes_seen == w0, "R1", "writes while disabled", writes_seen - w0, 0);
      chk(stats_seen == s0, "R1", "status while disabled", stats_seen - s0, 0);

      cfg_enable = 1'b1;
      // R3 pass-through, matching address (R8)
      send(mk(cfg_station_addr, 16'h0800, 64, 1'b0), 7, -1, 1'b1, "R3", "R8");
      idle(20);
      // R2 no preamble, foreign address
      send(mk(OTHER_DA, 16'h0800, 70, 1'b0), 0, -1, 1'b1, "R2", "R8");
      idle(20);
      // R2 single preamble byte
      send(mk(cfg_station_addr, 16'h0806, 65, 1'b0), 1, -1, 1'b1, "R2", "R6");
      idle(20);
      // R7 corrupted FCS
      send(mk(cfg_station_addr, 16'h0800, 64, 1'b1), 7, -1, 1'b1, "R3", "R7");
      idle(20);
      // R9 short and long
      send(mk(cfg_station_addr, 16'h0800, 40, 1'b0), 7, -1, 1'b1, "R3", "R9");
      idle(20);
      send(mk(cfg_station_addr, 16'h0800, 1530, 1'b0), 7, -1, 1'b1, "R3", "R9");
      idle(20);
      // R10 line error
      send(mk(cfg_station_addr, 16'h0800, 80, 1'b0), 7, 30, 1'b1, "R3", "R10");
      idle(20);
      // R11 tight gap, then exact minimum gap
      send(mk(cfg_station_addr, 16'h0800, 64, 1'b0), 7, -1, 1'b1, "R3", "R11");
      idle(5);
      send(mk(cfg_station_addr, 16'h0800, 64, 1'b0), 7, -1, 1'b1, "R3", "R11");
      idle(12);
      send(mk(cfg_station_addr, 16'h0800, 64, 1'b0), 7, -1, 1'b1, "R3", "R11");
      idle(20);
      // R13 control frames, good and bad CRC
      send(mk(CTL_DA, 16'h8808, 64, 1'b0), 7, -1, 1'b1, "R3", "R13");
      idle(20);
      send(mk(CTL_DA, 16'h8808, 64, 1'b1), 7, -1, 1'b1, "R3", "R13");
      idle(20);
      // R12 overflow
      fifo_full = 1'b1;
      send(mk(cfg_station_addr, 16'h0800, 64, 1'b0), 7, -1, 1'b1, "R12", "R12");
      idle(5);
      fifo_full = 1'b0;
      idle(15);
      // R4 / R5 strip mode
      cfg_strip = 1'b1;
      send(mk(cfg_station_addr, 16'h0800, 100, 1'b0), 7, -1, 1'b1, "R4", "R6");
      idle(20);
      send(mk(cfg_station_addr, 16'd20, 64, 1'b0), 7, -1, 1'b1, "R5", "R6");
      idle(20);
      send(mk(cfg_station_addr, 16'd46, 64, 1'b0), 7, -1, 1'b1, "R5", "R6");
      idle(20);
      send(mk(cfg_station_addr, 16'd45, 64, 1'b0), 3, -1, 1'b1, "R5", "R6");
      idle(20);
      cfg_strip = 1'b0;

      chk(exp_bytes.size() == 0, "R3", "bytes never written", exp_bytes.size(), 0);
      chk(exp_stat.size() == 0, "R6", "status never reported", exp_stat.size(), 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule